// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time (seconds, minutes, hours) and a calendar date (day, month, year offset from 2010) behind a small 32-bit register port. A one-second tick is made by a prescaler that counts enable pulses from a 32768 Hz low-speed oscillator. The block runs on the bus clock and receives that oscillator as a one-cycle enable, `slow_en`.

Software writes to the time or date register are first staged. They reach the live counters only after a fixed number of slow-clock pulses. Busy flags in the control register show that a write is still in flight. The control register holds the oscillator source select, a drive-strength bit and an auto-switchover enable. It changes only when the write carries a key in its upper half-word.

A status register reports which oscillator is active. Hardware does not work out leap years. Software supplies the leap flag with the date, and the calendar uses that flag to choose between a 28-day and a 29-day February.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the control register reads 0, status reads 0, time reads 0 and date reads 0x00000101 (day 1, month 1, year 0, leap 0).
- R2: The time register at offset 0x14 holds seconds in [5:0], minutes in [13:8] and hours in [20:16]. All other bits read 0. A written value appears in the counters on the BUSY_TICKS-th `slow_en` pulse after the write.
- R3: The date register at offset 0x10 holds day in [4:0], month in [11:8], year offset in [21:16] and the leap flag in bit 22. All other bits read 0. A written value is transferred like a time write.
- R4: Control bit 7 is set while a time write is pending, bit 8 while a date write is pending, and bit 9 while either is pending. Each bit is set from the clock edge that takes the write until the BUSY_TICKS-th `slow_en` pulse after it. A new write to the same register restarts its wait.
- R5: A write to the control register at offset 0x00 changes state only when bits [31:16] equal 0x16AA. Any other write leaves the readback unchanged.
- R6: Control bit 0 (source select), bit 3 (drive strength) and bit 14 (auto switchover) are stored and read back. Status bit 0 at offset 0x04 equals source & (ext_osc_ok | ~auto).
- R7: The seconds count advances once every 2^PRESCALE_W `slow_en` pulses. A time transfer resets the prescaler, so the first second after it ends on the 2^PRESCALE_W-th pulse after the transfer.
- R8: Seconds and minutes wrap from 59 to 0 with a carry. Hours wrap from 23 to 0 and advance the day.
- R9: The day wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11, 29 or 28 for month 2 (leap flag set or clear), and 31 otherwise. The leap flag is kept across a month change within the year.
- R10: A wrap from month 12 to 1 increments the 6-bit year offset (63 wraps to 0) and clears the leap flag.
- R11: Reads at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One-cycle pulse per 32768 Hz oscillator period |
| ext_osc_ok | input | 1 | External oscillator is running |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
The bench builds the block with PRESCALE_W = 3, so one second is eight slow pulses. This puts every rollover within a few pulses of a loaded value: month ends of 30, 31, 28 and 29 days, the year wrap from 63 and the plain minute carry. BUSY_TICKS stays at 2, so the bench can check the busy window pulse by pulse: still set after the first pulse and clear after the second.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int PRESCALE_W = 15,
  parameter int BUSY_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_en,
  input  logic        ext_osc_ok,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int CW = $clog2(BUSY_TICKS + 1);
  localparam logic [7:0] A_CTL = 8'h00, A_STA = 8'h04, A_DATE = 8'h10, A_TIME = 8'h14;
  localparam logic [15:0] KEY = 16'h16AA;

  logic [PRESCALE_W-1:0] presc;
  logic [CW-1:0] cnt_t, cnt_d;
  logic [5:0] sec, mins, yr;
  logic [4:0] hr, day, mlast;
  logic [3:0] mon;
  logic leap, c_src, c_drv, c_auto;
  logic [20:0] pend_t;
  logic [22:0] pend_d;

  wire wr_ctl  = bus_we && bus_addr == A_CTL && bus_wdata[31:16] == KEY;
  wire wr_time = bus_we && bus_addr == A_TIME;
  wire wr_date = bus_we && bus_addr == A_DATE;
  wire busy_t  = cnt_t != '0;
  wire busy_d  = cnt_d != '0;
  wire load_t  = !wr_time && slow_en && cnt_t == CW'(1);
  wire load_d  = !wr_date && slow_en && cnt_d == CW'(1);
  wire sec_tick = slow_en && !load_t && presc == '1;
  wire day_roll = sec_tick && sec == 6'd59 && mins == 6'd59 && hr == 5'd23;
  wire mon_roll = day_roll && !load_d && day >= mlast;
  wire active_src = c_src & (ext_osc_ok | ~c_auto);

  always_comb begin
    case (mon)
      4'd2: mlast = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: mlast = 5'd30;
      default: mlast = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_src <= 1'b0; c_drv <= 1'b0; c_auto <= 1'b0;
    end else if (wr_ctl) begin
      c_src <= bus_wdata[0]; c_drv <= bus_wdata[3]; c_auto <= bus_wdata[14];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_t <= '0; cnt_d <= '0; pend_t <= '0; pend_d <= '0;
    end else begin
      if (wr_time) begin
        cnt_t <= CW'(BUSY_TICKS); pend_t <= bus_wdata[20:0];
      end else if (slow_en && busy_t) cnt_t <= cnt_t - 1'b1;
      if (wr_date) begin
        cnt_d <= CW'(BUSY_TICKS); pend_d <= bus_wdata[22:0];
      end else if (slow_en && busy_d) cnt_d <= cnt_d - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0; sec <= '0; mins <= '0; hr <= '0;
    end else if (load_t) begin
      presc <= '0;
      sec <= pend_t[5:0]; mins <= pend_t[13:8]; hr <= pend_t[20:16];
    end else begin
      if (slow_en) presc <= presc + 1'b1;
      if (sec_tick) begin
        if (sec == 6'd59) begin
          sec <= '0;
          if (mins == 6'd59) begin
            mins <= '0;
            hr <= (hr == 5'd23) ? 5'd0 : hr + 5'd1;
          end else mins <= mins + 6'd1;
        end else sec <= sec + 6'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day <= 5'd1; mon <= 4'd1; yr <= '0; leap <= 1'b0;
    end else if (load_d) begin
      day <= pend_d[4:0]; mon <= pend_d[11:8]; yr <= pend_d[21:16]; leap <= pend_d[22];
    end else if (day_roll) begin
      if (day >= mlast) begin
        day <= 5'd1;
        if (mon >= 4'd12) begin
          mon <= 4'd1; yr <= yr + 6'd1; leap <= 1'b0;
        end else mon <= mon + 4'd1;
      end else day <= day + 5'd1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:  bus_rdata = {17'b0, c_auto, 4'b0, busy_t | busy_d, busy_d, busy_t, 3'b0, c_drv, 2'b0, c_src};
      A_STA:  bus_rdata = {31'b0, active_src};
      A_DATE: bus_rdata = {9'b0, leap, yr, 4'b0, mon, 3'b0, day};
      A_TIME: bus_rdata = {11'b0, hr, 2'b0, mins, 2'b0, sec};
      default: bus_rdata = '0;
    endcase
  end

  // R4
  time_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> bus_addr != A_CTL || bus_rdata[7]);
  // R5
  ctl_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CTL && bus_wdata[31:16] != KEY) |=> $stable({c_src, c_drv, c_auto}));
  // R7
  presc_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_t |=> presc == '0);
  // R8
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec == 6'd59) |=> sec == 6'd0);
  // R10
  year_leap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_roll && mon >= 4'd12) |=> (!leap && yr == $past(yr) + 6'd1 && mon == 4'd1));
endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  logic clk = 0, rst_n = 0, slow_en = 0, ext_osc_ok = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rtc_calendar #(.PRESCALE_W(3), .BUSY_TICKS(2)) u0 (
    .clk, .rst_n, .slow_en, .ext_osc_ok, .bus_we, .bus_addr, .bus_wdata, .bus_rdata);

  // {date_in, time_in, date_exp, time_exp} after one second
  localparam logic [31:0] VEC [9][4] = '{
    '{32'h0005021C, 32'h00173B3B, 32'h00050301, 32'h00000000},
    '{32'h0046021C, 32'h00173B3B, 32'h0046021D, 32'h00000000},
    '{32'h0046021D, 32'h00173B3B, 32'h00460301, 32'h00000000},
    '{32'h0000041E, 32'h00173B3B, 32'h00000501, 32'h00000000},
    '{32'h0000091E, 32'h00173B3B, 32'h00000A01, 32'h00000000},
    '{32'h0000011F, 32'h00173B3B, 32'h00000201, 32'h00000000},
    '{32'h007F0C1F, 32'h00173B3B, 32'h00000101, 32'h00000000},
    '{32'h00090C1F, 32'h00173B3B, 32'h000A0101, 32'h00000000},
    '{32'h0003070F, 32'h00000A3B, 32'h0003070F, 32'h00000B00}};

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_en = 1;
      @(negedge clk); slow_en = 0;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rst_n = 1;
        // R1
        chk("R1", 8'h00, 0); chk("R1", 8'h04, 0);
        chk("R1", 8'h10, 32'h101); chk("R1", 8'h14, 0);
        // R11
        chk("R11", 8'h08, 0);
        // R2 R4: busy window
        wr(8'h14, 32'hFFFF_0102);
        chk("R4", 8'h00, 32'h280);
        pulse(1); chk("R4", 8'h00, 32'h280); chk("R2", 8'h14, 0);
        pulse(1); chk("R4", 8'h00, 0); chk("R2", 8'h14, 32'h001F0102 & 32'h001F3F3F);
        // R3 R4: date busy and mask
        wr(8'h10, 32'hFF46_0A1D);
        chk("R4", 8'h00, 32'h300);
        pulse(2); chk("R3", 8'h10, 32'h00460A1D); chk("R4", 8'h00, 0);
        // R4: rewrite restarts wait
        wr(8'h14, 32'h1); pulse(1); wr(8'h14, 32'h2); pulse(1);
        chk("R4", 8'h00, 32'h280); pulse(1); chk("R4", 8'h14, 32'h2);
        // R5 R6
        wr(8'h00, 32'h1234_4009); chk("R5", 8'h00, 0);
        wr(8'h00, 32'h16AA_4009); chk("R6", 8'h00, 32'h4009);
        chk("R6", 8'h04, 0);
        ext_osc_ok = 1; chk("R6", 8'h04, 1);
        wr(8'h00, 32'h16AA_0001); ext_osc_ok = 0; chk("R6", 8'h04, 1);
        wr(8'h00, 32'h0000_0000); chk("R5", 8'h00, 32'h1);
        // R7 R8 R9 R10: table walk
        foreach (VEC[i]) begin
          wr(8'h10, VEC[i][0]); wr(8'h14, VEC[i][1]); pulse(2);
          chk("R2", 8'h14, VEC[i][1]);
          pulse(7); chk("R7", 8'h14, VEC[i][1]);
          pulse(1);
          chk(i >= 6 ? "R10" : "R9", 8'h10, VEC[i][2]);
          chk("R8", 8'h14, VEC[i][3]);
        end
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule